// File: doc/BRIEF.md
# DMA Channel State Controller

This block holds the control/status word and the lifecycle state machine of one DMA channel. The same logic serves a transfer channel or an event channel. Software writes a command byte into the upper field of the word and then polls the state byte until the command has taken effect. The block tracks five states: disabled, enabled, running, suspended and stopped. Enabled and running both count as an active channel.

A doorbell write carries the ring offset up to which descriptors have been queued. That write moves an enabled channel to running. A read pointer advances once for each descriptor the external mover finishes. When the read pointer reaches the doorbell offset, the channel drops back to enabled.

Suspend and reset commands do not take effect at once. The block first waits until the datapath reports that no transaction is still in flight. It then counts a programmable number of quiesce cycles before it reports the new state. A fatal error input forces the stopped state, and only a reset command leaves it.

Top module: `chan_state_ctl`

## Requirements
- R1: After reset the state byte reads 0 (disabled), the read pointer is 0, and `chanEnabled` and `workGrant` are low.
- R2: `regRdData` carries the state code in bits 15:8 and zero in every other bit. A write takes its command only from bits 23:16, so a value placed in any other bits of `regWrData` has no effect.
- R3: Command 1 (enable) in the disabled or suspended state gives state 1 (enabled) one cycle after the write. In the other states it is ignored.
- R4: A doorbell write while enabled, with an offset different from the read pointer, gives state 2 (running) one cycle later. Doorbell writes in the disabled, suspended or stopped state change neither the state nor the stored offset.
- R5: The read pointer advances by one on each `descDone` while it differs from the stored doorbell offset, and wraps from RING_DEPTH-1 to 0. A running channel whose read pointer equals the offset returns to state 1 on the next cycle.
- R6: Command 2 (suspend) in state 1 or 2 drops `workGrant` on the next cycle. The reported state is held while `inFlight` is high. After `inFlight` goes low, the state becomes 3 (suspended) on the (quiesceDelay+1)-th edge, where quiesceDelay is the value sampled at the command.
- R7: Command 3 (reset) is accepted in any state and drains in the same way as suspend. It ends in state 0 with the read pointer and the stored offset cleared. A reset that arrives during a suspend drain changes the drain's target to disabled without restarting the count.
- R8: A command of 0 or 4 to 255 is ignored. Enable and suspend commands written while a drain is pending are ignored.
- R9: A high `fatalErr` in any state other than disabled gives state 4 (stopped) on the next cycle and cancels a pending drain. In the stopped state only command 3 has an effect. `fatalErr` in the disabled state is ignored.
- R10: `chanEnabled` is high exactly when the state is 1 or 2. `workGrant` is high exactly when the state is 2 and no drain is pending.
- R11: When a suspend or reset command and a doorbell write fall in the same cycle, the command is taken and the doorbell is discarded, so its offset is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the control/status word |
| regWrData | input | 32 | Write data; command byte in bits 23:16 |
| regRdData | output | 32 | Read data; state byte in bits 15:8 |
| doorbellWr | input | 1 | Doorbell write strobe |
| doorbellOff | input | PTR_W | Queued-descriptor offset carried by the doorbell |
| descDone | input | 1 | The mover finished one descriptor |
| inFlight | input | 1 | The datapath still has a transaction outstanding |
| fatalErr | input | 1 | Fatal error from the datapath |
| quiesceDelay | input | QD_W | Extra cycles a drain waits once nothing is in flight |
| rdPtr | output | PTR_W | Descriptor read pointer |
| chanEnabled | output | 1 | Channel is enabled or running |
| workGrant | output | 1 | The datapath may start new work |

## Verification
Two kinds of event can land in the same cycle and compete. The first is a doorbell write together with a suspend command. The second is a fatal error while a suspend or reset is still draining. The bench drives each pair on a single clock edge. In the first case it checks that the channel ends up suspended and that the doorbell offset was dropped: after a later enable, `descDone` pulses leave the read pointer where it was. In the second case it checks that the stopped state appears on the very next edge and that no later drain completion overrides it.

// File: rtl/chan_state_pkg.sv
package chan_state_pkg;

  localparam int FIELD_W   = 8;
  localparam int STATE_LSB = 8;
  localparam int CMD_LSB   = 16;

  typedef enum logic [2:0] {
    ST_DIS  = 3'd0,
    ST_ENA  = 3'd1,
    ST_RUN  = 3'd2,
    ST_SUSP = 3'd3,
    ST_STOP = 3'd4
  } chanState_e;

  localparam logic [FIELD_W-1:0] CMD_ENABLE  = 8'd1;
  localparam logic [FIELD_W-1:0] CMD_SUSPEND = 8'd2;
  localparam logic [FIELD_W-1:0] CMD_RESET   = 8'd3;

  // strobes from the control FSM to the pointer/counter datapath
  typedef struct packed {
    logic ldQuiesce;
    logic cntDec;
    logic clrPtrs;
    logic storeDb;
  } dpStrobe_t;

endpackage

// File: rtl/chan_dp.sv
module chan_dp
  import chan_state_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int QD_W       = 8,
  localparam int PTR_W     = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PTR_W-1:0] doorbellOff,
  input  logic             descDone,
  input  logic [QD_W-1:0]  quiesceDelay,
  output logic [PTR_W-1:0] rdPtr,
  output logic             ptrsEqual,
  output logic             qZero
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(RING_DEPTH - 1);

  logic [PTR_W-1:0] dbOff;
  logic [PTR_W-1:0] rdPtrQ;
  logic [PTR_W-1:0] rdPtrInc;
  logic [QD_W-1:0]  qCnt;

  assign ptrsEqual = (dbOff == rdPtrQ);
  assign qZero     = (qCnt == '0);
  assign rdPtr     = rdPtrQ;
  assign rdPtrInc  = (rdPtrQ == LAST_IDX) ? '0 : rdPtrQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbOff  <= '0;
      rdPtrQ <= '0;
    end else if (strobe.clrPtrs) begin
      dbOff  <= '0;
      rdPtrQ <= '0;
    end else begin
      if (strobe.storeDb) dbOff <= doorbellOff;
      if (descDone && !ptrsEqual) rdPtrQ <= rdPtrInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 qCnt <= '0;
    else if (strobe.ldQuiesce) qCnt <= quiesceDelay;
    else if (strobe.cntDec)    qCnt <= qCnt - 1'b1;
  end

endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_state_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [FIELD_W-1:0] cmdField,
  input  logic               doorbellWr,
  input  logic [PTR_W-1:0]   doorbellOff,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic               ptrsEqual,
  input  logic               qZero,
  input  logic               inFlight,
  input  logic               fatalErr,
  output chanState_e         state,
  output logic               draining,
  output dpStrobe_t          strobe
);

  chanState_e stateQ, stateN, targetQ, targetN, effTarget;
  logic drainQ, drainN;
  logic cmdEn, cmdSus, cmdRst, fatalHit, drainStep, finish;
  logic acceptEn, acceptSus, acceptRst, dbOk, isActive;

  assign cmdEn  = regWrEn && (cmdField == CMD_ENABLE);
  assign cmdSus = regWrEn && (cmdField == CMD_SUSPEND);
  assign cmdRst = regWrEn && (cmdField == CMD_RESET);

  assign isActive  = (stateQ == ST_ENA) || (stateQ == ST_RUN);
  assign fatalHit  = fatalErr && (stateQ != ST_DIS);
  assign drainStep = drainQ && !inFlight;
  assign finish    = drainStep && qZero;

  assign acceptRst = cmdRst && !fatalHit;
  assign acceptSus = cmdSus && !fatalHit && !drainQ && isActive;
  assign acceptEn  = cmdEn && !fatalHit && !drainQ &&
                     ((stateQ == ST_DIS) || (stateQ == ST_SUSP));
  assign dbOk      = doorbellWr && !fatalHit && !drainQ && isActive &&
                     !acceptSus && !acceptRst;
  assign effTarget = acceptRst ? ST_DIS : targetQ;

  always_comb begin
    stateN  = stateQ;
    drainN  = drainQ;
    targetN = targetQ;
    strobe  = '0;
    if (fatalHit) begin
      stateN = ST_STOP;
      drainN = 1'b0;
    end else if (drainQ) begin
      if (acceptRst) targetN = ST_DIS;
      if (finish) begin
        stateN         = effTarget;
        drainN         = 1'b0;
        strobe.clrPtrs = (effTarget == ST_DIS);
      end else begin
        strobe.cntDec = drainStep;
      end
    end else if (acceptRst || acceptSus) begin
      drainN           = 1'b1;
      targetN          = acceptRst ? ST_DIS : ST_SUSP;
      strobe.ldQuiesce = 1'b1;
    end else if (acceptEn) begin
      stateN = ST_ENA;
    end else if (dbOk) begin
      strobe.storeDb = 1'b1;
      if ((stateQ == ST_ENA) && (doorbellOff != rdPtr)) stateN = ST_RUN;
    end else if ((stateQ == ST_RUN) && ptrsEqual) begin
      stateN = ST_ENA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_DIS;
      targetQ <= ST_DIS;
      drainQ  <= 1'b0;
    end else begin
      stateQ  <= stateN;
      targetQ <= targetN;
      drainQ  <= drainN;
    end
  end

  assign state    = stateQ;
  assign draining = drainQ;

endmodule

// File: rtl/chan_state_ctl.sv
module chan_state_ctl
  import chan_state_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int QD_W       = 8,
  localparam int PTR_W     = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             doorbellWr,
  input  logic [PTR_W-1:0] doorbellOff,
  input  logic             descDone,
  input  logic             inFlight,
  input  logic             fatalErr,
  input  logic [QD_W-1:0]  quiesceDelay,
  output logic [PTR_W-1:0] rdPtr,
  output logic             chanEnabled,
  output logic             workGrant
);

  chanState_e curState;
  logic       drainBusy;
  logic       ptrsEqual;
  logic       qZero;
  dpStrobe_t  strobe;
  logic       unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:CMD_LSB+FIELD_W], regWrData[CMD_LSB-1:0]};

  chan_ctrl #(.PTR_W(PTR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .cmdField   (regWrData[CMD_LSB +: FIELD_W]),
    .doorbellWr (doorbellWr),
    .doorbellOff(doorbellOff),
    .rdPtr      (rdPtr),
    .ptrsEqual  (ptrsEqual),
    .qZero      (qZero),
    .inFlight   (inFlight),
    .fatalErr   (fatalErr),
    .state      (curState),
    .draining   (drainBusy),
    .strobe     (strobe)
  );

  chan_dp #(.RING_DEPTH(RING_DEPTH), .QD_W(QD_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .doorbellOff (doorbellOff),
    .descDone    (descDone),
    .quiesceDelay(quiesceDelay),
    .rdPtr       (rdPtr),
    .ptrsEqual   (ptrsEqual),
    .qZero       (qZero)
  );

  always_comb begin
    regRdData = '0;
    regRdData[STATE_LSB +: FIELD_W] = FIELD_W'(curState);
  end

  assign chanEnabled = (curState == ST_ENA) || (curState == ST_RUN);
  assign workGrant   = (curState == ST_RUN) && !drainBusy;

endmodule

// File: rtl/chan_state_ctl_chk.sv
module chan_state_ctl_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [31:0]      regWrData,
  input logic [31:0]      regRdData,
  input logic             doorbellWr,
  input logic             inFlight,
  input logic             fatalErr,
  input logic [PTR_W-1:0] rdPtr,
  input logic             workGrant,
  input logic             drainBusy
);

  logic [7:0] st;
  logic [7:0] cmd;
  assign st  = regRdData[15:8];
  assign cmd = regWrData[23:16];

  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && cmd == 8'd1 && (st == 8'd0 || st == 8'd3) && !drainBusy && !(fatalErr && st != 8'd0)
    |=> st == 8'd1); // R3

  AST_RUN_FROM_DOORBELL: assert property (@(posedge clk) disable iff (!rstN)
    (st == 8'd2) && ($past(st) == 8'd1) |-> $past(doorbellWr)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdPtr) |-> (rdPtr == '0) || (rdPtr == PTR_W'($past(rdPtr) + 1'b1))); // R5

  AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && cmd == 8'd2 && st == 8'd2 |=> !workGrant); // R6

  AST_INFLIGHT_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    drainBusy && inFlight && !fatalErr |=> $stable(st)); // R6

  AST_FATAL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr && st != 8'd0 |=> st == 8'd4); // R9

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    st == 8'd4 && !drainBusy && !(regWrEn && cmd == 8'd3) |=> st == 8'd4); // R9

endmodule

bind chan_state_ctl chan_state_ctl_chk #(.PTR_W(PTR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .doorbellWr(doorbellWr),
  .inFlight  (inFlight),
  .fatalErr  (fatalErr),
  .rdPtr     (rdPtr),
  .workGrant (workGrant),
  .drainBusy (drainBusy)
);

// File: tb/chan_state_ctl_test.sv
module chan_state_ctl_test;

  localparam int RING_DEPTH = 8;
  localparam int QD_W       = 8;
  localparam int PTR_W      = 3;
  localparam int S_DIS = 0, S_ENA = 1, S_RUN = 2, S_SUSP = 3, S_STOP = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic             doorbellWr = 1'b0;
  logic [PTR_W-1:0] doorbellOff = '0;
  logic             descDone = 1'b0;
  logic             inFlight = 1'b0;
  logic             fatalErr = 1'b0;
  logic [QD_W-1:0]  quiesceDelay = '0;
  logic [PTR_W-1:0] rdPtr;
  logic             chanEnabled;
  logic             workGrant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0]      qRd[$];
  logic             qEn[$];
  logic             qGr[$];
  logic [PTR_W-1:0] qPtr[$];
  string            qTag[$];

  always #10 clk = ~clk;

  chan_state_ctl #(.RING_DEPTH(RING_DEPTH), .QD_W(QD_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .doorbellWr(doorbellWr), .doorbellOff(doorbellOff),
    .descDone(descDone), .inFlight(inFlight), .fatalErr(fatalErr),
    .quiesceDelay(quiesceDelay), .rdPtr(rdPtr), .chanEnabled(chanEnabled),
    .workGrant(workGrant)
  );

  // monitor: compares after each edge the item pushed before it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (qTag.size() > 0) begin
        logic [31:0] eRd;
        logic eEn, eGr;
        logic [PTR_W-1:0] ePtr;
        string tag;
        eRd = qRd.pop_front(); eEn = qEn.pop_front(); eGr = qGr.pop_front();
        ePtr = qPtr.pop_front(); tag = qTag.pop_front();
        checks++;
        if (regRdData !== eRd || chanEnabled !== eEn || workGrant !== eGr || rdPtr !== ePtr) begin
          fails++;
          $display("FAIL %s: actual rd=%h en=%b grant=%b ptr=%0d expected rd=%h en=%b grant=%b ptr=%0d",
                   tag, regRdData, chanEnabled, workGrant, rdPtr, eRd, eEn, eGr, ePtr);
        end
      end
    end
  end

  // driver: push the expectation for the next edge, then advance one cycle
  task automatic exp(int st, bit gr, int ptr, string tag);
    qRd.push_back(32'(st) << 8);
    qEn.push_back(st == S_ENA || st == S_RUN);
    qGr.push_back(gr);
    qPtr.push_back(PTR_W'(ptr));
    qTag.push_back(tag);
    @(negedge clk);
    regWrEn = 1'b0; doorbellWr = 1'b0; descDone = 1'b0; fatalErr = 1'b0;
  endtask

  task automatic cmd(int c);
    regWrEn = 1'b1; regWrData = 32'(c) << 16;
  endtask

  task automatic ring(int off);
    doorbellWr = 1'b1; doorbellOff = PTR_W'(off);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    exp(S_DIS, 0, 0, "R1 reset state");
    // R2: only bits 23:16 carry a command
    regWrEn = 1'b1; regWrData = 32'h0100_0101;
    exp(S_DIS, 0, 0, "R2 command outside field");
    // R8: invalid codes
    cmd(0);    exp(S_DIS, 0, 0, "R8 code 0");
    cmd(5);    exp(S_DIS, 0, 0, "R8 code 5");
    cmd(255);  exp(S_DIS, 0, 0, "R8 code 255");
    // R4: doorbell ignored while disabled
    ring(3);   exp(S_DIS, 0, 0, "R4 doorbell in disabled");
    descDone = 1'b1; exp(S_DIS, 0, 0, "R4 offset not stored");
    // R3 / R10
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable from disabled");
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable in enabled");
    ring(2);   exp(S_RUN, 1, 0, "R4 doorbell starts run");
    descDone = 1'b1; exp(S_RUN, 1, 1, "R5 pointer step");
    descDone = 1'b1; exp(S_RUN, 1, 2, "R5 pointer reaches offset");
    exp(S_ENA, 0, 2, "R5 back to enabled");
    descDone = 1'b1; exp(S_ENA, 0, 2, "R5 pointer held at offset");
    // R5 wrap
    ring(1);   exp(S_RUN, 1, 2, "R5 doorbell behind pointer");
    for (int k = 1; k <= 7; k++) begin
      descDone = 1'b1; exp(S_RUN, 1, (2 + k) % RING_DEPTH, "R5 wrap walk");
    end
    exp(S_ENA, 0, 1, "R5 after wrap");
    // R6 suspend with in-flight work
    quiesceDelay = 8'd2;
    ring(3);   exp(S_RUN, 1, 1, "R4 run again");
    inFlight = 1'b1; cmd(2); exp(S_RUN, 0, 1, "R6 grant drops");
    for (int k = 0; k < 3; k++) exp(S_RUN, 0, 1, "R6 held while in flight");
    inFlight = 1'b0;
    exp(S_RUN, 0, 1, "R6 quiesce count 1");
    exp(S_RUN, 0, 1, "R6 quiesce count 2");
    exp(S_SUSP, 0, 1, "R6 suspended");
    ring(5);   exp(S_SUSP, 0, 1, "R4 doorbell in suspended");
    cmd(1);    exp(S_ENA, 0, 1, "R3 enable from suspended");
    // R7 reset
    quiesceDelay = 8'd0;
    cmd(3);    exp(S_ENA, 0, 1, "R7 reset pending");
    exp(S_DIS, 0, 0, "R7 reset done");
    // R7 retarget
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    ring(4);   exp(S_RUN, 1, 0, "R4 run");
    quiesceDelay = 8'd3;
    cmd(2);    exp(S_RUN, 0, 0, "R6 suspend pending");
    cmd(3);    exp(S_RUN, 0, 0, "R7 reset retargets");
    exp(S_RUN, 0, 0, "R7 draining");
    exp(S_RUN, 0, 0, "R7 draining");
    exp(S_DIS, 0, 0, "R7 retarget ends disabled");
    // R8 suspend during reset drain ignored
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    quiesceDelay = 8'd1;
    cmd(3);    exp(S_ENA, 0, 0, "R7 reset pending");
    cmd(2);    exp(S_ENA, 0, 0, "R8 suspend during drain");
    exp(S_DIS, 0, 0, "R8 drain kept reset target");
    // R9 fatal error
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    ring(2);   exp(S_RUN, 1, 0, "R4 run");
    fatalErr = 1'b1; exp(S_STOP, 0, 0, "R9 fatal stops");
    cmd(1);    exp(S_STOP, 0, 0, "R9 enable in stopped");
    cmd(2);    exp(S_STOP, 0, 0, "R9 suspend in stopped");
    ring(6);   exp(S_STOP, 0, 0, "R9 doorbell in stopped");
    quiesceDelay = 8'd0;
    cmd(3);    exp(S_STOP, 0, 0, "R9 reset from stopped");
    exp(S_DIS, 0, 0, "R9 reset leaves stopped");
    fatalErr = 1'b1; exp(S_DIS, 0, 0, "R9 fatal in disabled");
    // R9 fatal cancels drain
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    quiesceDelay = 8'd2;
    cmd(2);    exp(S_ENA, 0, 0, "R6 suspend pending");
    fatalErr = 1'b1; exp(S_STOP, 0, 0, "R9 fatal during drain");
    for (int k = 0; k < 3; k++) exp(S_STOP, 0, 0, "R9 drain cancelled");
    // R11 suspend and doorbell in the same cycle
    quiesceDelay = 8'd0;
    cmd(3);    exp(S_STOP, 0, 0, "R7 reset");
    exp(S_DIS, 0, 0, "R7 reset done");
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    cmd(2); ring(3); exp(S_ENA, 0, 0, "R11 suspend with doorbell");
    exp(S_SUSP, 0, 0, "R11 suspend wins");
    cmd(1);    exp(S_ENA, 0, 0, "R3 enable");
    descDone = 1'b1; exp(S_ENA, 0, 0, "R11 doorbell offset dropped");
    exp(S_ENA, 0, 0, "R11 stays enabled");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule